// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one vector arithmetic instruction across the elements of its source vectors, one element per clock. It presents an element index to an external register file, takes the two operand elements back in the same cycle, and passes each result through a pipeline whose depth depends on the operation. The first result therefore appears only after the start-up latency. After that, one result leaves per clock. A run takes start-up latency plus the vector length in cycles.

A vector-length register sets how many elements an instruction covers. A mask register can gate write-back: on a masked instruction, an element whose mask bit is clear still uses its clock slot but produces no write. The mask is loaded in one of two ways. A compare-equal instruction sets each bit from an element-wise equality test of the two sources. A mask-load instruction copies the bits from a scalar input.

Top module: `vseq_unit`

## Requirements
- R1: A pulse on `vl_wr` loads the vector-length register from `vl_din` on that edge. A value above MAXVL is stored as MAXVL. `vl_out` shows the stored value.
- R2: For opcode 0 (add), element i is written with `wr_en`=1, `wr_idx`=i and `wr_data` equal to the sum of the two sources modulo 2^DW. This happens in the cycle that follows the ADD_LAT+i-th clock edge after the edge that accepted the start.
- R3: For opcode 1 (multiply), the low DW bits of the product are written for element i MUL_LAT+i edges after the accepting edge.
- R4: During the k-th cycle after the accepting edge (k counted from 0), `rd_idx` equals k for k below the length, and the operands present in that cycle belong to element k.
- R5: `busy` is high for exactly latency+n cycles, starting in the cycle after the accepting edge. `done` is high for one cycle right after that. A length of 0 gives latency busy cycles and no writes.
- R6: With `use_mask`=1, an element whose mask bit (bit i belongs to element i) is 0 causes no write, and every later element keeps its timing.
- R7: With `use_mask`=0, every element below the length is written, whatever the mask holds.
- R8: Opcode 2 (compare-equal) sets mask bit i to 1 when the two source elements are equal and to 0 otherwise, for every i below the length. Bits at or above the length keep their value. The instruction makes no write, and its timing follows the add latency.
- R9: Opcode 3 (mask load), when accepted, copies `mask_din` into the mask on that edge (bit i to bit i). It raises neither `busy` nor `done`.
- R10: A start while `busy` is high is ignored, whatever the opcode.
- R11: After reset, `busy`, `done` and `wr_en` are 0, the mask is all ones and the length is MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vl_wr | input | 1 | Load the vector-length register |
| vl_din | input | VLW | New vector length |
| start | input | 1 | Start the instruction on `opcode` |
| opcode | input | 2 | 0 add, 1 multiply, 2 compare-equal, 3 mask load |
| use_mask | input | 1 | Gate write-back with the mask |
| mask_din | input | MAXVL | Scalar value for the mask load |
| rd_idx | output | IW | Index of the element being fetched |
| src_a | input | DW | First source element for `rd_idx` |
| src_b | input | DW | Second source element for `rd_idx` |
| wr_en | output | 1 | Result write enable |
| wr_idx | output | IW | Destination element index |
| wr_data | output | DW | Result element |
| mask_out | output | MAXVL | Current mask register |
| vl_out | output | VLW | Current vector length |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
Properties checked on every cycle: `done` is a single-cycle pulse that follows the fall of `busy`; writes occur only while `busy` is high and only to indices below the captured length; results leave the pipeline in ascending index order; the instruction state holds across a start that arrives while busy; and the mask changes only through a mask load or an active compare. Only the bench's scenarios can confirm the rest: the exact cycle of each write under each latency, the arithmetic values, which elements a given mask suppresses, the mask that a compare leaves behind, saturation of the length register, and the zero-length run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_MUL = 2'd1,
      OP_CMP = 2'd2,
      OP_LDM = 2'd3
   } vop_e;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
   import vseq_pkg::*;
#(
   parameter int ADD_LAT = 6,
   parameter int MUL_LAT = 7,
   parameter int MAXVL   = 8,
   localparam int VLW = $clog2(MAXVL + 1),
   localparam int IW  = $clog2(MAXVL),
   localparam int SW  = $clog2(MUL_LAT),
   localparam int CW  = $clog2(MUL_LAT + MAXVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  vop_e           op_i,
   input  logic           msk_i,
   input  logic [VLW-1:0] vl_i,
   output logic           busy_o,
   output logic           done_o,
   output logic           issue_v_o,
   output logic [IW-1:0]  issue_idx_o,
   output vop_e           op_o,
   output logic           msk_o,
   output logic [VLW-1:0] len_o,
   output logic [SW-1:0]  tap_o
);
   logic [CW-1:0]  cnt_q, total_q;
   logic           busy_q, done_q, msk_q;
   vop_e           op_q;
   logic [VLW-1:0] len_q;
   logic           accept;

   function automatic int lat_of(input vop_e o);
      return (o == OP_MUL) ? MUL_LAT : ADD_LAT;
   endfunction

   initial begin
      assert (ADD_LAT >= 2 && MUL_LAT >= ADD_LAT && MAXVL >= 2)
         else $error("vseq_ctrl: latency or length parameters out of range");
   end

   assign accept = start_i && !busy_q && (op_i != OP_LDM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         total_q <= '0;
         op_q    <= OP_ADD;
         msk_q   <= 1'b0;
         len_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            op_q    <= op_i;
            msk_q   <= msk_i;
            len_q   <= vl_i;
            total_q <= CW'(lat_of(op_i)) + CW'(vl_i);
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == total_q - 1'b1) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign issue_v_o   = busy_q && (cnt_q < CW'(len_q));
   assign issue_idx_o = cnt_q[IW-1:0];
   assign op_o        = op_q;
   assign msk_o       = msk_q;
   assign len_o       = len_q;
   assign tap_o       = SW'(lat_of(op_q) - 1);

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> ($stable(op_q) && $stable(len_q) && $stable(msk_q)));
   assert_issue_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_v_o |-> (CW'(issue_idx_o) < CW'(len_q)));
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu
   import vseq_pkg::*;
#(
   parameter int DW    = 16,
   parameter int MAXVL = 8,
   localparam int IW = $clog2(MAXVL)
) (
   input  logic          valid_i,
   input  logic [IW-1:0] idx_i,
   input  vop_e          op_i,
   input  logic          msk_i,
   input  logic          mask_bit_i,
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic          valid_o,
   output logic          wr_o,
   output logic          cmp_o,
   output logic          eq_o,
   output logic [IW-1:0] idx_o,
   output logic [DW-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_MUL:  res_o = a_i * b_i;
         default: res_o = a_i + b_i;
      endcase
   end

   assign valid_o = valid_i;
   assign cmp_o   = (op_i == OP_CMP);
   assign eq_o    = (a_i == b_i);
   assign wr_o    = valid_i && (op_i != OP_CMP) && (!msk_i || mask_bit_i);
   assign idx_o   = idx_i;
endmodule

// File: rtl/vseq_delay.sv
module vseq_delay #(
   parameter int W     = 24,
   parameter int DEPTH = 7,
   localparam int SW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] tap,
   output logic [W-1:0]  dout
);
   logic [W-1:0] taps [DEPTH];

   initial begin
      assert (DEPTH >= 2) else $error("vseq_delay: DEPTH must be at least 2");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_stg
      logic [W-1:0] q;
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stg[k-1].q;
         end
      end
      assign taps[k] = q;
   end

   assign dout = taps[tap];
endmodule

// File: rtl/vseq_unit.sv
module vseq_unit
   import vseq_pkg::*;
#(
   parameter int DW      = 16,
   parameter int MAXVL   = 8,
   parameter int ADD_LAT = 6,
   parameter int MUL_LAT = 7,
   localparam int VLW = $clog2(MAXVL + 1),
   localparam int IW  = $clog2(MAXVL),
   localparam int SW  = $clog2(MUL_LAT),
   localparam int PW  = 4 + IW + DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vl_wr,
   input  logic [VLW-1:0]   vl_din,
   input  logic             start,
   input  logic [1:0]       opcode,
   input  logic             use_mask,
   input  logic [MAXVL-1:0] mask_din,
   output logic [IW-1:0]    rd_idx,
   input  logic [DW-1:0]    src_a,
   input  logic [DW-1:0]    src_b,
   output logic             wr_en,
   output logic [IW-1:0]    wr_idx,
   output logic [DW-1:0]    wr_data,
   output logic [MAXVL-1:0] mask_out,
   output logic [VLW-1:0]   vl_out,
   output logic             busy,
   output logic             done
);
   vop_e             op_in, op_q;
   logic [MAXVL-1:0] mask_q;
   logic [VLW-1:0]   vl_q, len_q;
   logic             issue_v, msk_q;
   logic [IW-1:0]    issue_idx;
   logic [SW-1:0]    tap;
   logic             ldm_go;

   logic             a_v, a_wr, a_cmp, a_eq;
   logic [IW-1:0]    a_idx;
   logic [DW-1:0]    a_res;
   logic [PW-1:0]    pipe_in, pipe_out;

   logic             o_v, o_wr, o_cmp, o_eq;
   logic [IW-1:0]    o_idx;
   logic [DW-1:0]    o_res;

   assign op_in = vop_e'(opcode);

   vseq_ctrl #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .MAXVL(MAXVL)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_in), .msk_i(use_mask),
      .vl_i(vl_q), .busy_o(busy), .done_o(done), .issue_v_o(issue_v),
      .issue_idx_o(issue_idx), .op_o(op_q), .msk_o(msk_q), .len_o(len_q), .tap_o(tap)
   );

   vseq_alu #(.DW(DW), .MAXVL(MAXVL)) u_alu (
      .valid_i(issue_v), .idx_i(issue_idx), .op_i(op_q), .msk_i(msk_q),
      .mask_bit_i(mask_q[issue_idx]), .a_i(src_a), .b_i(src_b),
      .valid_o(a_v), .wr_o(a_wr), .cmp_o(a_cmp), .eq_o(a_eq), .idx_o(a_idx), .res_o(a_res)
   );

   assign pipe_in = {a_v, a_wr, a_cmp, a_eq, a_idx, a_res};

   vseq_delay #(.W(PW), .DEPTH(MUL_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .din(pipe_in), .tap(tap), .dout(pipe_out)
   );

   assign {o_v, o_wr, o_cmp, o_eq, o_idx, o_res} = pipe_out;

   assign ldm_go = start && !busy && (op_in == OP_LDM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (ldm_go) begin
         mask_q <= mask_din;
      end else if (o_v && o_cmp) begin
         mask_q[o_idx] <= o_eq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vl_q <= VLW'(MAXVL);
      else if (vl_wr) vl_q <= (vl_din > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_din;
   end

   assign rd_idx   = issue_idx;
   assign wr_en    = o_v && o_wr;
   assign wr_idx   = o_idx;
   assign wr_data  = o_res;
   assign mask_out = mask_q;
   assign vl_out   = vl_q;

   assert_write_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
   assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_idx} < (IW+1)'(len_q)));
   assert_ordered_results_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_v && $past(o_v)) |-> (o_idx == $past(o_idx) + 1'b1));
   assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ldm_go) |=> $stable(mask_q));
   assert_vl_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= VLW'(MAXVL));
endmodule

// File: tb/vseq_unit_test.sv
module vseq_unit_test;
   localparam int CLK_NS  = 10;
   localparam int DW      = 16;
   localparam int MAXVL   = 8;
   localparam int ADD_LAT = 6;
   localparam int MUL_LAT = 7;
   localparam int VLW     = 4;
   localparam int IW      = 3;

   typedef struct {
      int            cyc;
      int            idx;
      logic [DW-1:0] data;
      string         req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             vl_wr = 1'b0;
   logic [VLW-1:0]   vl_din = '0;
   logic             start = 1'b0;
   logic [1:0]       opcode = 2'd0;
   logic             use_mask = 1'b0;
   logic [MAXVL-1:0] mask_din = '0;
   logic [IW-1:0]    rd_idx;
   logic [DW-1:0]    src_a, src_b;
   logic             wr_en;
   logic [IW-1:0]    wr_idx;
   logic [DW-1:0]    wr_data;
   logic [MAXVL-1:0] mask_out;
   logic [VLW-1:0]   vl_out;
   logic             busy, done;

   logic [DW-1:0]    va [MAXVL];
   logic [DW-1:0]    vb [MAXVL];
   logic [MAXVL-1:0] exp_mask;
   exp_t             sb [$];
   int               cyc = 0;
   int               n_chk = 0;
   int               n_err = 0;
   bit               over = 1'b0;

   vseq_unit uut (
      .clk(clk), .rst_n(rst_n), .vl_wr(vl_wr), .vl_din(vl_din), .start(start),
      .opcode(opcode), .use_mask(use_mask), .mask_din(mask_din), .rd_idx(rd_idx),
      .src_a(src_a), .src_b(src_b), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .mask_out(mask_out), .vl_out(vl_out), .busy(busy), .done(done)
   );

   always #(CLK_NS/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign src_a = va[rd_idx];
   assign src_b = vb[rd_idx];

   task automatic chk(input string req, input bit ok, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: compares each write against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && !over) begin
         if (sb.size() > 0 && sb[0].cyc < cyc) begin
            exp_t m;
            m = sb.pop_front();
            chk(m.req, 1'b0, "missing write at cycle", cyc, m.cyc);
         end
         if (wr_en) begin
            if (sb.size() == 0) begin
               chk("R6 R8", 1'b0, "unexpected write idx", wr_idx, -1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(e.req, e.cyc == cyc, "write cycle", cyc, e.cyc);
               chk(e.req, int'(wr_idx) == e.idx, "write index", wr_idx, e.idx);
               chk(e.req, wr_data == e.data, "write data", wr_data, e.data);
            end
         end
      end
   end

   task automatic set_vl(input int v, input int expect_v);
      @(negedge clk);
      vl_wr = 1'b1; vl_din = VLW'(v);
      @(negedge clk);
      vl_wr = 1'b0;
      chk("R1", int'(vl_out) == expect_v, "vector length", vl_out, expect_v);
   endtask

   task automatic run_op(input logic [1:0] op, input bit um, input int n,
                         input bit intrude, input string req);
      int c0, lat, bcnt, done_cyc;
      lat = (op == 2'd1) ? MUL_LAT : ADD_LAT;
      @(negedge clk);
      opcode = op; use_mask = um; start = 1'b1;
      c0 = cyc + 1;
      for (int i = 0; i < n; i++) begin
         if (op != 2'd2 && (!um || exp_mask[i])) begin
            exp_t e;
            logic [DW-1:0] r;
            if (op == 2'd1) r = va[i] * vb[i];
            else            r = va[i] + vb[i];
            e.cyc = c0 + lat + i; e.idx = i; e.data = r; e.req = req;
            sb.push_back(e);
         end
      end
      @(negedge clk);
      start = 1'b0;
      bcnt = 0; done_cyc = -1;
      for (int k = 0; k < 60; k++) begin
         if (intrude && k == 2) begin
            start = 1'b1; opcode = 2'd3; mask_din = ~exp_mask;
         end
         if (intrude && k == 3) begin
            start = 1'b0; opcode = op;
         end
         if (busy) bcnt++;
         if (done) begin
            done_cyc = cyc;
            break;
         end
         @(negedge clk);
      end
      chk("R5", done_cyc == c0 + lat + n, "done cycle", done_cyc, c0 + lat + n);
      chk("R5", bcnt == lat + n, "busy cycles", bcnt, lat + n);
      if (op == 2'd2) begin
         for (int i = 0; i < n; i++) exp_mask[i] = (va[i] == vb[i]);
         chk("R8", mask_out == exp_mask, "mask after compare", mask_out, exp_mask);
      end
      @(negedge clk);
      chk(req, sb.size() == 0, "pending writes", sb.size(), 0);
      sb.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!over) begin
         over = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = '0; vb[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", busy == 1'b0, "busy", busy, 0);
      chk("R11", done == 1'b0, "done", done, 0);
      chk("R11", wr_en == 1'b0, "wr_en", wr_en, 0);
      chk("R11", mask_out == '1, "mask", mask_out, 8'hFF);
      chk("R11", int'(vl_out) == MAXVL, "length", vl_out, MAXVL);
      exp_mask = '1;

      // R1 saturation and plain load
      set_vl(13, MAXVL);
      set_vl(5, 5);

      // R2 R4 R7 unmasked add, mask content must not matter
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = DW'(100 * i + 3); vb[i] = DW'(7 * i + 1);
      end
      run_op(2'd0, 1'b0, 5, 1'b0, "R2 R4 R7");

      // R3 multiply with wrap-around
      set_vl(8, 8);
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = DW'(16'hF000 + 777 * i); vb[i] = DW'(3 + i);
      end
      run_op(2'd1, 1'b0, 8, 1'b0, "R3");

      // R9 mask load from scalar
      @(negedge clk);
      opcode = 2'd3; mask_din = 8'hA6; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      exp_mask = 8'hA6;
      chk("R9", mask_out == 8'hA6, "mask after load", mask_out, 8'hA6);
      chk("R9", busy == 1'b0, "busy after load", busy, 0);
      @(negedge clk);
      chk("R9", done == 1'b0, "done after load", done, 0);

      // R6 masked add: only bits 1,2,5,7 write
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = DW'(50 + i); vb[i] = DW'(1000 * i);
      end
      run_op(2'd0, 1'b1, 8, 1'b0, "R6");

      // R7 unmasked multiply with a sparse mask
      run_op(2'd1, 1'b0, 8, 1'b0, "R7");

      // R8 compare over 6 elements, bits 6 and 7 keep their value
      set_vl(6, 6);
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = DW'(5 * i);
         vb[i] = (i % 2 == 0) ? DW'(5 * i) : DW'(5 * i + 1);
      end
      run_op(2'd2, 1'b0, 6, 1'b0, "R8");

      // R6 R8 masked multiply under the compare-built mask
      for (int i = 0; i < MAXVL; i++) begin
         va[i] = DW'(300 + 11 * i); vb[i] = DW'(9 + i);
      end
      run_op(2'd1, 1'b1, 6, 1'b0, "R6 R8");

      // R5 zero length
      set_vl(0, 0);
      run_op(2'd0, 1'b0, 0, 1'b0, "R5");

      // R10 start while busy is ignored
      set_vl(4, 4);
      run_op(2'd0, 1'b0, 4, 1'b1, "R10");
      chk("R10", mask_out == exp_mask, "mask after ignored load", mask_out, exp_mask);

      repeat (3) @(negedge clk);
      if (!over) begin
         over = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule